// File: doc/BRIEF.md
# Prefix-Primed Block Transfer Controller

This block sits beside a core's retire stage and owns a hidden transfer register (Q) that prefix instructions fill. Each retire slot presents one already-decoded instruction: a class code, an operand and a valid strobe. From the current instruction and the stored prefix state, the block works out in the same cycle how many 32-bit words a block read or write moves, how far the hub pointer moves afterwards, whether the instruction uses Q, and whether a core launch should load Q into the new core's start pointer.

Two prefix kinds write the same Q. The general prefix primes block reads, block writes and core launches. The block-only prefix primes only block reads and writes. Address-modifier instructions (augment and alter types) leave either prefix primed. Every other instruction retires the prefix. A parameter selects between two behaviours when a modifier sits between a prefix and a block transfer. In legacy mode the pointer moves by only one word. In fixed mode the pointer keeps its full block-size step.

Top module: `prefix_xfer_ctl`

## Requirements
- R1: After reset, Q reads 0 and no prefix is primed. A block read then reports 1 word, and `launch_ld` stays low.
- R2: A valid general prefix (class 1) or block-only prefix (class 2) writes `ins_opnd` into Q. The new value appears on `q_value` from the next cycle.
- R3: A block read (class 4) or block write (class 5) primed by either prefix reports Q+1 words on `xfer_longs`. A block-only prefix has no effect on a core launch (class 7).
- R4: For a primed block transfer, `ptr_delta` is (Q+1)*4 when `ptr_mode` is 1 (post-increment) and -(Q+1)*4 when it is 2 (post-decrement). It is 0 when `ptr_mode` is 0 (no pointer update). This holds up to Q = 2^QW-1.
- R5: An unprimed block read or write reports 1 word and a delta of +4, -4 or 0 according to `ptr_mode`.
- R6: Any valid instruction of class 0, 4, 5, 6 or 7 clears both prefix flags after it retires.
- R7: A modifier (class 3) keeps the prefix flags and Q as they were, so a block transfer after it still moves Q+1 words.
- R8: With KEEP_BLK_DELTA = 0, a modifier retired between the prefix and a block transfer reduces the pointer delta to a single word (±4). The word count stays Q+1.
- R9: With KEEP_BLK_DELTA = 1, a block transfer after an intervening modifier keeps the (Q+1)*4 pointer delta.
- R10: A Q-read instruction (class 6) always raises `q_used`, whatever the prefix state.
- R11: A core launch (class 7) raises `launch_ld` and `q_used` only when the previous valid instruction was a general prefix. Any other valid instruction in between, a modifier included, blocks the load.
- R12: A cycle with `ins_vld` low changes no state, and it drives `xfer_longs`, `ptr_delta`, `q_used` and `launch_ld` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_vld | input | 1 | Retire-slot valid strobe |
| ins_cls | input | 4 | Instruction class: 0 other, 1 general prefix, 2 block-only prefix, 3 modifier, 4 block read, 5 block write, 6 Q read, 7 core launch |
| ins_opnd | input | QW | Operand (Q value for prefixes) |
| ptr_mode | input | 2 | Pointer update: 0 none, 1 post-increment, 2 post-decrement |
| xfer_longs | output | QW+1 | Words moved by the current block transfer |
| ptr_delta | output | QW+4 | Signed pointer change in bytes |
| q_used | output | 1 | Current instruction consumes Q |
| launch_ld | output | 1 | Load Q into the launched core's start pointer |
| q_value | output | QW | Current Q contents |

## Verification
The bench feeds two copies of the block, one built with each setting of KEEP_BLK_DELTA. It runs several patterns through them: a prefix directly followed by a transfer, a prefix with a modifier between it and the transfer, a prefix with a plain instruction between, and prefixes separated by idle slots. Prefix then modifier then read is the one pattern that separates the two parameter settings. Prefix, filler, launch against prefix then launch tests the strict adjacency rule for launches. A block-only prefix followed by a launch shows that the two flags are kept apart. The largest Q with both pointer directions tests the edge of the count and delta widths.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
  typedef enum logic [3:0] {
    CLS_OTHER     = 4'd0,
    CLS_QLOAD     = 4'd1,
    CLS_QLOAD_BLK = 4'd2,
    CLS_MODIFY    = 4'd3,
    CLS_BLK_RD    = 4'd4,
    CLS_BLK_WR    = 4'd5,
    CLS_QREAD     = 4'd6,
    CLS_LAUNCH    = 4'd7
  } ins_cls_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_INC  = 2'd1,
    PM_DEC  = 2'd2
  } ptr_mode_e;

  localparam int unsigned WORD_BYTES_LOG2 = 2;
endpackage

// File: rtl/pbx_reset_sync.sv
module pbx_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pbx_prime_state.sv
module pbx_prime_state
  import pbx_pkg::*;
#(
  parameter int unsigned QW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  ins_cls_e      cls,
  input  logic [QW-1:0] opnd,
  output logic [QW-1:0] q_reg,
  output logic          prime_gen,
  output logic          prime_blk,
  output logic          mod_seen,
  output logic          follow_gen
);
  logic [QW-1:0] q_nxt;
  logic          prime_gen_nxt, prime_blk_nxt, mod_seen_nxt, follow_gen_nxt;

  always_comb begin
    q_nxt          = q_reg;
    prime_gen_nxt  = 1'b0;
    prime_blk_nxt  = 1'b0;
    mod_seen_nxt   = 1'b0;
    follow_gen_nxt = 1'b0;
    unique case (cls)
      CLS_QLOAD: begin
        q_nxt          = opnd;
        prime_gen_nxt  = 1'b1;
        follow_gen_nxt = 1'b1;
      end
      CLS_QLOAD_BLK: begin
        q_nxt         = opnd;
        prime_blk_nxt = 1'b1;
      end
      CLS_MODIFY: begin
        prime_gen_nxt = prime_gen;
        prime_blk_nxt = prime_blk;
        mod_seen_nxt  = mod_seen | prime_gen | prime_blk;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg      <= '0;
      prime_gen  <= 1'b0;
      prime_blk  <= 1'b0;
      mod_seen   <= 1'b0;
      follow_gen <= 1'b0;
    end else if (vld) begin
      q_reg      <= q_nxt;
      prime_gen  <= prime_gen_nxt;
      prime_blk  <= prime_blk_nxt;
      mod_seen   <= mod_seen_nxt;
      follow_gen <= follow_gen_nxt;
    end
  end
endmodule

// File: rtl/pbx_xfer_calc.sv
module pbx_xfer_calc
  import pbx_pkg::*;
#(
  parameter int unsigned QW             = 10,
  parameter bit          KEEP_BLK_DELTA = 1'b0,
  localparam int unsigned CW = QW + 1,
  localparam int unsigned DW = QW + 4
) (
  input  logic                 vld,
  input  ins_cls_e             cls,
  input  ptr_mode_e            pmode,
  input  logic [QW-1:0]        q_reg,
  input  logic                 prime_gen,
  input  logic                 prime_blk,
  input  logic                 mod_seen,
  input  logic                 follow_gen,
  output logic [CW-1:0]        xfer_longs,
  output logic signed [DW-1:0] ptr_delta,
  output logic                 q_used,
  output logic                 launch_ld
);
  logic [CW-1:0]        q_plus;
  logic                 is_blk, primed, blk_step_ok;
  logic signed [DW-1:0] step_bytes;

  assign q_plus = {1'b0, q_reg} + CW'(1);
  assign is_blk = (cls == CLS_BLK_RD) || (cls == CLS_BLK_WR);
  assign primed = prime_gen | prime_blk;

  generate
    if (KEEP_BLK_DELTA) begin : g_keep
      assign blk_step_ok = primed;
    end else begin : g_legacy
      assign blk_step_ok = primed & ~mod_seen;
    end
  endgenerate

  always_comb begin
    step_bytes = blk_step_ok ? $signed({1'b0, q_plus, {WORD_BYTES_LOG2{1'b0}}})
                             : DW'(signed'(4));
    xfer_longs = '0;
    ptr_delta  = '0;
    q_used     = 1'b0;
    launch_ld  = 1'b0;
    if (vld) begin
      if (is_blk) begin
        xfer_longs = primed ? q_plus : CW'(1);
        q_used     = primed;
        unique case (pmode)
          PM_INC:  ptr_delta = step_bytes;
          PM_DEC:  ptr_delta = -step_bytes;
          default: ptr_delta = '0;
        endcase
      end
      if (cls == CLS_QREAD) q_used = 1'b1;
      if (cls == CLS_LAUNCH && follow_gen) begin
        q_used    = 1'b1;
        launch_ld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prefix_xfer_ctl.sv
module prefix_xfer_ctl
  import pbx_pkg::*;
#(
  parameter int unsigned QW             = 10,
  parameter bit          KEEP_BLK_DELTA = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_vld,
  input  logic [3:0]           ins_cls,
  input  logic [QW-1:0]        ins_opnd,
  input  logic [1:0]           ptr_mode,
  output logic [QW:0]          xfer_longs,
  output logic signed [QW+3:0] ptr_delta,
  output logic                 q_used,
  output logic                 launch_ld,
  output logic [QW-1:0]        q_value
);
  logic      rst_sync_n;
  logic      prime_gen, prime_blk, mod_seen, follow_gen;
  ins_cls_e  cls_e;
  ptr_mode_e pm_e;

  assign cls_e = ins_cls_e'(ins_cls);
  assign pm_e  = ptr_mode_e'(ptr_mode);

  pbx_reset_sync #(.STAGES(2)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pbx_prime_state #(.QW(QW)) u_state (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .vld        (ins_vld),
    .cls        (cls_e),
    .opnd       (ins_opnd),
    .q_reg      (q_value),
    .prime_gen  (prime_gen),
    .prime_blk  (prime_blk),
    .mod_seen   (mod_seen),
    .follow_gen (follow_gen)
  );

  pbx_xfer_calc #(.QW(QW), .KEEP_BLK_DELTA(KEEP_BLK_DELTA)) u_calc (
    .vld        (ins_vld),
    .cls        (cls_e),
    .pmode      (pm_e),
    .q_reg      (q_value),
    .prime_gen  (prime_gen),
    .prime_blk  (prime_blk),
    .mod_seen   (mod_seen),
    .follow_gen (follow_gen),
    .xfer_longs (xfer_longs),
    .ptr_delta  (ptr_delta),
    .q_used     (q_used),
    .launch_ld  (launch_ld)
  );
endmodule

// File: rtl/prefix_xfer_ctl_chk.sv
module prefix_xfer_ctl_chk #(
  parameter int unsigned QW = 10
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 ins_vld,
  input logic [3:0]           ins_cls,
  input logic [QW-1:0]        ins_opnd,
  input logic [QW:0]          xfer_longs,
  input logic signed [QW+3:0] ptr_delta,
  input logic                 q_used,
  input logic                 launch_ld,
  input logic [QW-1:0]        q_value
);
  a_r2_qload_captures: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ins_vld && ins_cls == 4'd1) |=> (q_value == $past(ins_opnd)));

  a_r12_idle_holds_q: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ins_vld |=> $stable(q_value));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ins_vld |-> (xfer_longs == '0 && ptr_delta == '0 && !q_used && !launch_ld));

  a_r10_qread_uses_q: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ins_vld && ins_cls == 4'd6) |-> q_used);

  a_r11_launch_only_on_launch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    launch_ld |-> (ins_vld && ins_cls == 4'd7 && q_used));

  a_r11_launch_after_prefix: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ins_vld && ins_cls == 4'd7 && $past(ins_vld && ins_cls == 4'd1)) |-> launch_ld);

  a_r3_blk_count_nonzero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ins_vld && (ins_cls == 4'd4 || ins_cls == 4'd5)) |-> (xfer_longs != '0));
endmodule

bind prefix_xfer_ctl prefix_xfer_ctl_chk #(.QW(QW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ins_vld    (ins_vld),
  .ins_cls    (ins_cls),
  .ins_opnd   (ins_opnd),
  .xfer_longs (xfer_longs),
  .ptr_delta  (ptr_delta),
  .q_used     (q_used),
  .launch_ld  (launch_ld),
  .q_value    (q_value)
);

// File: tb/prefix_xfer_ctl_bench.sv
module prefix_xfer_ctl_bench;
  localparam int QW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_vld;
  logic [3:0] ins_cls;
  logic [QW-1:0] ins_opnd;
  logic [1:0] ptr_mode;

  logic [QW:0]          cnt_a, cnt_b;
  logic signed [QW+3:0] dlt_a, dlt_b;
  logic                 qu_a, qu_b, ld_a, ld_b;
  logic [QW-1:0]        qv_a, qv_b;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_q = 0;
  bit m_gen = 0, m_blk = 0, m_mod = 0, m_fol = 0;

  always #5 clk = ~clk;

  prefix_xfer_ctl #(.QW(QW), .KEEP_BLK_DELTA(1'b0)) u_prefix_xfer_ctl (
    .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_cls(ins_cls),
    .ins_opnd(ins_opnd), .ptr_mode(ptr_mode), .xfer_longs(cnt_a),
    .ptr_delta(dlt_a), .q_used(qu_a), .launch_ld(ld_a), .q_value(qv_a));

  prefix_xfer_ctl #(.QW(QW), .KEEP_BLK_DELTA(1'b1)) u_prefix_xfer_ctl_keep (
    .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_cls(ins_cls),
    .ins_opnd(ins_opnd), .ptr_mode(ptr_mode), .xfer_longs(cnt_b),
    .ptr_delta(dlt_b), .q_used(qu_b), .launch_ld(ld_b), .q_value(qv_b));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req, input bit keep, input int cnt, input int dlt,
                         input bit qu, input bit ld, input int qv);
    bit blk, primed, full;
    int step, e_cnt, e_dlt;
    bit e_qu, e_ld;
    blk = ins_vld && (ins_cls == 4 || ins_cls == 5);
    primed = m_gen || m_blk;
    full = primed && (keep || !m_mod);
    step = full ? (m_q + 1) * 4 : 4;
    e_cnt = blk ? (primed ? m_q + 1 : 1) : 0;
    e_dlt = !blk ? 0 : (ptr_mode == 1) ? step : (ptr_mode == 2) ? -step : 0;
    e_ld = ins_vld && ins_cls == 7 && m_fol;
    e_qu = (blk && primed) || (ins_vld && ins_cls == 6) || e_ld;
    check(req, keep ? "keep.count" : "legacy.count", cnt, e_cnt);
    check(req, keep ? "keep.delta" : "legacy.delta", dlt, e_dlt);
    check(req, keep ? "keep.q_used" : "legacy.q_used", int'(qu), int'(e_qu));
    check(req, keep ? "keep.launch" : "legacy.launch", int'(ld), int'(e_ld));
    check(req, keep ? "keep.q" : "legacy.q", qv, m_q);
  endtask

  task automatic step(input string req, input bit v, input int cls, input int opnd, input int pm);
    @(negedge clk);
    ins_vld = v; ins_cls = 4'(cls); ins_opnd = QW'(opnd); ptr_mode = 2'(pm);
    #2;
    compare(req, 1'b0, int'(cnt_a), int'(dlt_a), qu_a, ld_a, int'(qv_a));
    compare(req, 1'b1, int'(cnt_b), int'(dlt_b), qu_b, ld_b, int'(qv_b));
    if (v) begin
      case (cls)
        1: begin m_q = opnd; m_gen = 1; m_blk = 0; m_mod = 0; m_fol = 1; end
        2: begin m_q = opnd; m_gen = 0; m_blk = 1; m_mod = 0; m_fol = 0; end
        3: begin m_mod = m_mod || m_gen || m_blk; m_fol = 0; end
        default: begin m_gen = 0; m_blk = 0; m_mod = 0; m_fol = 0; end
      endcase
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ins_vld = 1'b0; ins_cls = '0; ins_opnd = '0; ptr_mode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 reset state
    step("R1", 1, 4, 0, 1);
    step("R1", 1, 7, 0, 0);
    // R2 R3 R4 prefix then read, post-increment
    step("R2", 1, 1, 15, 0);
    step("R3", 1, 4, 0, 1);
    // R7 R8 R9 prefix, modifier, read
    step("R7", 1, 1, 15, 0);
    step("R7", 1, 3, 0, 0);
    step("R8", 1, 4, 0, 1);
    step("R9", 1, 1, 15, 0);
    step("R9", 1, 3, 0, 0);
    step("R9", 1, 3, 0, 0);
    step("R9", 1, 5, 0, 2);
    // block-only prefix then write, post-decrement
    step("R2", 1, 2, 7, 0);
    step("R4", 1, 5, 0, 2);
    // block-only prefix ignored by launch
    step("R3", 1, 2, 3, 0);
    step("R3", 1, 7, 0, 0);
    // R11 launch adjacency
    step("R11", 1, 1, 5, 0);
    step("R11", 1, 0, 0, 0);
    step("R11", 1, 7, 0, 0);
    step("R11", 1, 1, 5, 0);
    step("R11", 1, 7, 0, 0);
    step("R11", 1, 1, 6, 0);
    step("R11", 1, 3, 0, 0);
    step("R11", 1, 7, 0, 0);
    // R6 plain instruction clears the prefix
    step("R6", 1, 1, 9, 0);
    step("R6", 1, 0, 0, 0);
    step("R6", 1, 4, 0, 1);
    // R5 unprimed transfers
    step("R5", 1, 5, 0, 2);
    step("R5", 1, 4, 0, 0);
    step("R5", 1, 4, 0, 1);
    // R10 Q read with and without a prefix
    step("R10", 1, 6, 0, 0);
    step("R10", 1, 2, 12, 0);
    step("R10", 1, 6, 0, 0);
    // R12 idle slots preserve the prefix
    step("R12", 1, 1, 3, 0);
    step("R12", 0, 1, 99, 1);
    step("R12", 0, 4, 0, 2);
    step("R12", 0, 7, 0, 0);
    step("R12", 1, 4, 0, 1);
    // R4 largest Q in both directions
    step("R4", 1, 1, 1023, 0);
    step("R4", 1, 4, 0, 1);
    step("R4", 1, 2, 1023, 0);
    step("R4", 1, 5, 0, 2);
    step("R4", 1, 1, 1023, 0);
    step("R4", 1, 4, 0, 0);
    // R1 reset again clears Q and flags
    step("R1", 1, 1, 20, 0);
    @(negedge clk) rst_n = 1'b0;
    ins_vld = 1'b0;
    m_q = 0; m_gen = 0; m_blk = 0; m_mod = 0; m_fol = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step("R1", 1, 4, 0, 1);
    step("R1", 1, 7, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule